// File: doc/BRIEF.md
# Four-Way Translation Buffer with Indexed Software Load

This block caches virtual-to-physical page translations in four ways of 32 sets each. Software stages a new entry in three registers through a simple write port. The first register holds the virtual page number and the address-space identifier. The second holds the physical page number and the attribute bits. The third selects the target way and the indexing mode. A one-cycle load strobe then copies the staged entry into the chosen way. The set it lands in is either the plain page-number slice 16..12, or that slice XORed with the low five bits of the address-space identifier.

A lookup presents a virtual address and an address-space identifier. One clock later the block reports a hit, with the physical page number and attributes, or a one-cycle miss. The edge that registers a miss also writes the faulting virtual page number into the staging register. A miss handler therefore only has to fill in the physical half before it issues the load.

The result stage is a three-state machine. RES_IDLE means no lookup was presented in the previous cycle. RES_HIT means the previous lookup matched one way. RES_MISS means it matched none. From any state the machine moves to RES_IDLE when no request is present, to RES_HIT when a request hits, and to RES_MISS when a request misses.

Top module: `tlb4way`

## Requirements
- R1: Reset clears every valid bit in all four ways and sets the staging registers to zero. After reset, lk_hit, lk_miss, lk_ppn, lk_attr and entry_hi are all zero, and no lookup hits.
- R2: Register writes take effect on the clock edge where reg_we is high. reg_sel=0 writes the entry-high register: page number from data bits 31..10 and identifier from bits 7..0. entry_hi returns these with bits 9..8 reading zero. reg_sel=1 writes the entry-low register. reg_sel=2 writes the control register: way in bits 1..0 and index mode in bit 4. reg_sel=3 writes nothing.
- R3: ld_en writes one entry into the way named by the control way field. With index mode 0 the set is entry-high bits 16..12. The entry stores: tag = entry-high bits 31..17 and 11..10; the identifier; valid = entry-low bit 8; physical page = entry-low bits 31..10; and attributes PR = bits 6..5, SZ = bit 4, C = bit 3, D = bit 2, SH = bit 1.
- R4: With index mode 1 the set is page bits 16..12 XOR identifier bits 4..0. This applies both to loads, using the entry-high register, and to lookups, using lk_vaddr and lk_asid.
- R5: A lookup hits when some way of the indexed set is valid, its tag equals lk_vaddr bits 31..17 and 11..10, and its identifier equals lk_asid. One cycle after lk_req, exactly one of lk_hit or lk_miss is high. On a hit, lk_ppn carries the physical page and lk_attr carries {PR[1:0], SZ, C, D, SH}, from bit 5 down to bit 0.
- R6: A miss captures lk_vaddr bits 31..10 into the entry-high page field on the same edge that raises lk_miss. The identifier field is left unchanged. If a software write to entry-high occurs on the same edge, the captured page number wins and the written identifier is kept.
- R7: An entry loaded with entry-low bit 8 clear never hits.
- R8: A lookup issued on the same cycle as a load sees the contents from before that load.
- R9: Loading a way and set that are already occupied replaces the old translation completely.
- R10: In a cycle after no request, lk_hit and lk_miss are low and lk_ppn and lk_attr are zero. After a miss, lk_ppn and lk_attr are also zero.
- R11: A load changes only the addressed way and set; every other entry keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 2 | Register select: 0 entry-high, 1 entry-low, 2 control, 3 none |
| reg_wdata | input | 32 | Register write data |
| ld_en | input | 1 | Load staged entry into the translation arrays |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_hit | output | 1 | Previous-cycle lookup hit |
| lk_miss | output | 1 | Previous-cycle lookup missed (one-cycle pulse) |
| lk_ppn | output | 22 | Physical page number of the hit |
| lk_attr | output | 6 | Attributes of the hit: {PR[1:0], SZ, C, D, SH} |
| entry_hi | output | 32 | Entry-high register: page number 31..10, zeros 9..8, identifier 7..0 |

## Verification
The bench fills all 128 entries with arithmetically distinct tags and physical pages, then looks each one up. A design that mixes up the way or set, or swaps attribute fields, therefore returns a wrong number at a precise place. A sweep over all 32 low identifier values with hashed indexing, followed by the same lookups unhashed, exposes a missing or mis-sliced XOR: only identifier 0 may still hit. Targeted cases cover a load and a lookup on the same edge (a design that forwards the new entry hits too early) and a software write colliding with a miss capture (a wrong priority loses the faulting page). They also cover an entry loaded as invalid, a replaced entry that must lose its old tag, and a reset in the middle of the run that must make every earlier translation miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Entry-low field positions; the load path decodes these bit offsets.
    localparam int EL_V_BIT   = 8;
    localparam int EL_PR_LSB  = 5;
    localparam int EL_SZ_BIT  = 4;
    localparam int EL_C_BIT   = 3;
    localparam int EL_D_BIT   = 2;
    localparam int EL_SH_BIT  = 1;

    // Control register: way field at the bottom, index mode bit above it.
    localparam int CTL_IX_BIT = 4;

    typedef struct packed {
        logic [1:0] pr;
        logic       sz;
        logic       c;
        logic       d;
        logic       sh;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);

    typedef enum logic [1:0] {
        SEL_HIGH = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RES_IDLE = 2'd0,
        RES_HIT  = 2'd1,
        RES_MISS = 2'd2
    } res_state_e;

endpackage

// File: rtl/tlb_set_index.sv
module tlb_set_index #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] vpn_slice,
    input  logic [IDX_W-1:0] asid_low,
    input  logic             hashed,
    output logic [IDX_W-1:0] set_idx
);

    always_comb begin
        if (hashed) begin
            set_idx = vpn_slice ^ asid_low;
        end else begin
            set_idx = vpn_slice;
        end
    end

endmodule

// File: rtl/tlb_stage_regs.sv
module tlb_stage_regs
    import tlb_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PAGE_LSB = 10,
    parameter int ASID_W   = 8,
    parameter int WAY_W    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [1:0]               reg_sel,
    input  logic [VA_W-1:0]          reg_wdata,
    input  logic                     cap_en,
    input  logic [VA_W-PAGE_LSB-1:0] cap_vpn,
    output logic [VA_W-PAGE_LSB-1:0] eh_vpn,
    output logic [ASID_W-1:0]        eh_asid,
    output logic [VA_W-PAGE_LSB-1:0] el_ppn,
    output logic                     el_valid,
    output attr_t                    el_attr,
    output logic [WAY_W-1:0]         ctl_way,
    output logic                     ctl_hashed
);

    localparam int VPN_W = VA_W - PAGE_LSB;

    reg_sel_e sel;
    logic     wr_high;
    logic     wr_low;
    logic     wr_ctl;
    logic     unused_gap_bit;

    assign sel            = reg_sel_e'(reg_sel);
    assign unused_gap_bit = reg_wdata[PAGE_LSB-1];

    always_comb begin
        wr_high = 1'b0;
        wr_low  = 1'b0;
        wr_ctl  = 1'b0;
        if (reg_we) begin
            unique case (sel)
                SEL_HIGH: wr_high = 1'b1;
                SEL_LOW:  wr_low  = 1'b1;
                SEL_CTRL: wr_ctl  = 1'b1;
                SEL_NONE: ;
            endcase
        end
    end

    // Entry-high: a miss capture takes the page field ahead of software.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eh_vpn  <= '0;
            eh_asid <= '0;
        end else begin
            if (cap_en) begin
                eh_vpn <= cap_vpn;
            end else if (wr_high) begin
                eh_vpn <= reg_wdata[VA_W-1:PAGE_LSB];
            end
            if (wr_high) begin
                eh_asid <= reg_wdata[ASID_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            el_ppn   <= '0;
            el_valid <= 1'b0;
            el_attr  <= '0;
        end else if (wr_low) begin
            el_ppn     <= reg_wdata[VA_W-1:PAGE_LSB];
            el_valid   <= reg_wdata[EL_V_BIT];
            el_attr.pr <= reg_wdata[EL_PR_LSB +: 2];
            el_attr.sz <= reg_wdata[EL_SZ_BIT];
            el_attr.c  <= reg_wdata[EL_C_BIT];
            el_attr.d  <= reg_wdata[EL_D_BIT];
            el_attr.sh <= reg_wdata[EL_SH_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_way    <= '0;
            ctl_hashed <= 1'b0;
        end else if (wr_ctl) begin
            ctl_way    <= reg_wdata[WAY_W-1:0];
            ctl_hashed <= reg_wdata[CTL_IX_BIT];
        end
    end

    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (eh_vpn == $past(cap_vpn)));                    // R6

    AST_ASID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !(reg_we && sel == SEL_HIGH)) |=> $stable(eh_asid)); // R6

    AST_NONE_SEL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && sel == SEL_NONE && !cap_en) |=>
            ($stable(eh_vpn) && $stable(eh_asid) && $stable(el_ppn) && $stable(ctl_way))); // R2

    logic [VPN_W-1:0] unused_width_probe;
    assign unused_width_probe = '0;

endmodule

// File: rtl/tlb_way.sv
module tlb_way
    import tlb_pkg::*;
#(
    parameter int NSETS  = 32,
    parameter int TAG_W  = 17,
    parameter int ASID_W = 8,
    parameter int PPN_W  = 22
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NSETS)-1:0] wr_idx,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic [ASID_W-1:0]        wr_asid,
    input  logic                     wr_valid,
    input  logic [PPN_W-1:0]         wr_ppn,
    input  attr_t                    wr_attr,
    input  logic [$clog2(NSETS)-1:0] rd_idx,
    input  logic [TAG_W-1:0]         rd_tag,
    input  logic [ASID_W-1:0]        rd_asid,
    output logic                     rd_hit,
    output logic [PPN_W-1:0]         rd_ppn,
    output attr_t                    rd_attr
);

    logic [NSETS-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [NSETS];
    logic [ASID_W-1:0] asid_q [NSETS];
    logic [PPN_W-1:0]  ppn_q  [NSETS];
    attr_t             attr_q [NSETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            asid_q[wr_idx] <= wr_asid;
            ppn_q[wr_idx]  <= wr_ppn;
            attr_q[wr_idx] <= wr_attr;
        end
    end

    always_comb begin
        rd_hit  = valid_q[rd_idx]
                  && (tag_q[rd_idx] == rd_tag)
                  && (asid_q[rd_idx] == rd_asid);
        rd_ppn  = ppn_q[rd_idx];
        rd_attr = attr_q[rd_idx];
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));                         // R1

    AST_WAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)] == $past(wr_valid)));    // R3

    AST_OTHER_WAYS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_q));                              // R11

endmodule

// File: rtl/tlb4way.sv
module tlb4way
    import tlb_pkg::*;
#(
    parameter int NWAYS    = 4,
    parameter int NSETS    = 32,
    parameter int VA_W     = 32,
    parameter int ASID_W   = 8,
    parameter int PAGE_LSB = 10,
    parameter int IDX_LSB  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [1:0]               reg_sel,
    input  logic [VA_W-1:0]          reg_wdata,
    input  logic                     ld_en,
    input  logic                     lk_req,
    input  logic [VA_W-1:0]          lk_vaddr,
    input  logic [ASID_W-1:0]        lk_asid,
    output logic                     lk_hit,
    output logic                     lk_miss,
    output logic [VA_W-PAGE_LSB-1:0] lk_ppn,
    output logic [ATTR_W-1:0]        lk_attr,
    output logic [VA_W-1:0]          entry_hi
);

    localparam int IDX_W    = $clog2(NSETS);
    localparam int WAY_W    = $clog2(NWAYS);
    localparam int VPN_W    = VA_W - PAGE_LSB;
    localparam int PPN_W    = VPN_W;
    localparam int TAG_HI_W = VA_W - IDX_LSB - IDX_W;
    localparam int TAG_LO_W = IDX_LSB - PAGE_LSB;
    localparam int TAG_W    = TAG_HI_W + TAG_LO_W;
    localparam int SLICE_LO = IDX_LSB - PAGE_LSB;

    // Staging registers
    logic [VPN_W-1:0]  eh_vpn;
    logic [ASID_W-1:0] eh_asid;
    logic [PPN_W-1:0]  el_ppn;
    logic              el_valid;
    attr_t             el_attr;
    logic [WAY_W-1:0]  ctl_way;
    logic              ctl_hashed;
    logic              cap_en;

    tlb_stage_regs #(
        .VA_W     (VA_W),
        .PAGE_LSB (PAGE_LSB),
        .ASID_W   (ASID_W),
        .WAY_W    (WAY_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .cap_en     (cap_en),
        .cap_vpn    (lk_vaddr[VA_W-1:PAGE_LSB]),
        .eh_vpn     (eh_vpn),
        .eh_asid    (eh_asid),
        .el_ppn     (el_ppn),
        .el_valid   (el_valid),
        .el_attr    (el_attr),
        .ctl_way    (ctl_way),
        .ctl_hashed (ctl_hashed)
    );

    assign entry_hi = {eh_vpn, {(PAGE_LSB-ASID_W){1'b0}}, eh_asid};

    // Set index for the load and the lookup paths
    logic [IDX_W-1:0] ld_idx;
    logic [IDX_W-1:0] lk_idx;

    tlb_set_index #(.IDX_W(IDX_W)) u_ld_index (
        .vpn_slice (eh_vpn[SLICE_LO +: IDX_W]),
        .asid_low  (eh_asid[IDX_W-1:0]),
        .hashed    (ctl_hashed),
        .set_idx   (ld_idx)
    );

    tlb_set_index #(.IDX_W(IDX_W)) u_lk_index (
        .vpn_slice (lk_vaddr[IDX_LSB +: IDX_W]),
        .asid_low  (lk_asid[IDX_W-1:0]),
        .hashed    (ctl_hashed),
        .set_idx   (lk_idx)
    );

    // Tags are the page bits on both sides of the index slice
    logic [TAG_W-1:0] ld_tag;
    logic [TAG_W-1:0] lk_tag;
    logic             unused_offset;

    assign ld_tag        = {eh_vpn[VPN_W-1 -: TAG_HI_W], eh_vpn[TAG_LO_W-1:0]};
    assign lk_tag        = {lk_vaddr[VA_W-1 -: TAG_HI_W], lk_vaddr[IDX_LSB-1:PAGE_LSB]};
    assign unused_offset = ^lk_vaddr[PAGE_LSB-1:0];

    // Ways
    logic [NWAYS-1:0]  way_hit;
    logic [PPN_W-1:0]  way_ppn  [NWAYS];
    logic [ATTR_W-1:0] way_attr [NWAYS];

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic  wr_sel;
        attr_t rd_attr_w;

        assign wr_sel      = ld_en && (ctl_way == WAY_W'(w));
        assign way_attr[w] = rd_attr_w;

        tlb_way #(
            .NSETS  (NSETS),
            .TAG_W  (TAG_W),
            .ASID_W (ASID_W),
            .PPN_W  (PPN_W)
        ) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_sel),
            .wr_idx   (ld_idx),
            .wr_tag   (ld_tag),
            .wr_asid  (eh_asid),
            .wr_valid (el_valid),
            .wr_ppn   (el_ppn),
            .wr_attr  (el_attr),
            .rd_idx   (lk_idx),
            .rd_tag   (lk_tag),
            .rd_asid  (lk_asid),
            .rd_hit   (way_hit[w]),
            .rd_ppn   (way_ppn[w]),
            .rd_attr  (rd_attr_w)
        );
    end

    logic              any_hit;
    logic [PPN_W-1:0]  hit_ppn;
    logic [ATTR_W-1:0] hit_attr;

    always_comb begin
        hit_ppn  = '0;
        hit_attr = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (way_hit[w]) begin
                hit_ppn  = hit_ppn  | way_ppn[w];
                hit_attr = hit_attr | way_attr[w];
            end
        end
    end

    assign any_hit = |way_hit;
    assign cap_en  = lk_req && !any_hit;

    // Result state machine
    res_state_e        res_q;
    res_state_e        res_d;
    logic [PPN_W-1:0]  ppn_q;
    logic [ATTR_W-1:0] attr_q;

    always_comb begin
        res_d = RES_IDLE;
        if (lk_req) begin
            res_d = any_hit ? RES_HIT : RES_MISS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= RES_IDLE;
            ppn_q  <= '0;
            attr_q <= '0;
        end else begin
            res_q  <= res_d;
            ppn_q  <= (res_d == RES_HIT) ? hit_ppn  : '0;
            attr_q <= (res_d == RES_HIT) ? hit_attr : '0;
        end
    end

    always_comb begin
        lk_hit  = 1'b0;
        lk_miss = 1'b0;
        unique case (res_q)
            RES_IDLE: ;
            RES_HIT:  lk_hit  = 1'b1;
            RES_MISS: lk_miss = 1'b1;
            default:  ;
        endcase
        lk_ppn  = ppn_q;
        lk_attr = attr_q;
    end

    AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));                                        // R5

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (lk_hit != lk_miss));                           // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!lk_hit && !lk_miss && lk_ppn == '0 && lk_attr == '0)); // R10

    AST_MISS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (entry_hi[VA_W-1:PAGE_LSB] == $past(lk_vaddr[VA_W-1:PAGE_LSB]))); // R6

endmodule

// File: tb/tb_tlb4way.sv
`timescale 1ns/1ps
module tb_tlb4way;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        ld_en = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit;
    logic        lk_miss;
    logic [21:0] lk_ppn;
    logic [5:0]  lk_attr;
    logic [31:0] entry_hi;

    always #2 clk = ~clk;

    tlb4way dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .ld_en     (ld_en),
        .lk_req    (lk_req),
        .lk_vaddr  (lk_vaddr),
        .lk_asid   (lk_asid),
        .lk_hit    (lk_hit),
        .lk_miss   (lk_miss),
        .lk_ppn    (lk_ppn),
        .lk_attr   (lk_attr),
        .entry_hi  (entry_hi)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        r_hit;
    logic        r_miss;
    logic [21:0] r_ppn;
    logic [5:0]  r_attr;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [21:0] vpn_of(int s, int w);
        return {15'(w * 37 + s + 100), 5'(s), 2'(s + w)};
    endfunction

    function automatic logic [21:0] ppn_of(int s, int w);
        return 22'(w * 4099 + s * 131 + 7);
    endfunction

    function automatic logic [5:0] attr_of(int s, int w);
        return 6'(s * 5 + w * 3 + 1);
    endfunction

    // Entry-low layout: PPN 31..10, V 8, PR 6..5, SZ 4, C 3, D 2, SH 1
    function automatic logic [31:0] el_word(logic [21:0] p, logic [5:0] a, logic v);
        return {p, 1'b0, v, 1'b0, a[5:4], a[3], a[2], a[1], a[0], 1'b0};
    endfunction

    function automatic logic [31:0] eh_word(logic [21:0] v, logic [7:0] asid);
        return {v, 2'b00, asid};
    endfunction

    function automatic logic [31:0] ctl_word(logic ix, int way);
        return {27'd0, ix, 2'b00, 2'(way)};
    endfunction

    task automatic wr(logic [1:0] sel, logic [31:0] data);
        reg_we    = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic load();
        ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic install(logic [21:0] v, logic [7:0] asid, logic [21:0] p,
                           logic [5:0] a, logic valid, logic ix, int way);
        wr(2'd0, eh_word(v, asid));
        wr(2'd1, el_word(p, a, valid));
        wr(2'd2, ctl_word(ix, way));
        load();
    endtask

    task automatic lookup(logic [21:0] v, logic [7:0] asid);
        lk_req   = 1'b1;
        lk_vaddr = {v, 10'h2A5};
        lk_asid  = asid;
        @(negedge clk);
        r_hit  = lk_hit;
        r_miss = lk_miss;
        r_ppn  = lk_ppn;
        r_attr = lk_attr;
        lk_req = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();

        // R1: state after reset
        chk("R1 hit after reset", lk_hit, 0);
        chk("R1 miss after reset", lk_miss, 0);
        chk("R1 ppn after reset", lk_ppn, 0);
        chk("R1 entry_hi after reset", entry_hi, 0);
        lookup(vpn_of(0, 0), 8'h00);
        chk("R1 empty lookup misses", r_hit, 0);

        // R2: register port encodings
        wr(2'd0, 32'hFFFF_FFFF);
        chk("R2 entry_hi gap bits read zero", entry_hi, 32'hFFFF_FCFF);
        wr(2'd3, 32'h1234_5678);
        chk("R2 select 3 writes nothing", entry_hi, 32'hFFFF_FCFF);
        wr(2'd1, 32'hAAAA_AAAA);
        chk("R2 entry-low write leaves entry_hi", entry_hi, 32'hFFFF_FCFF);

        // R3: fill every way of every set, index mode 0
        for (int s = 0; s < 32; s++) begin
            for (int w = 0; w < 4; w++) begin
                install(vpn_of(s, w), 8'h5A, ppn_of(s, w), attr_of(s, w), 1'b1, 1'b0, w);
            end
        end
        for (int s = 0; s < 32; s++) begin
            for (int w = 0; w < 4; w++) begin
                lookup(vpn_of(s, w), 8'h5A);
                chk("R3 R5 filled entry hits", r_hit, 1);
                chk("R3 R5 ppn of hit", r_ppn, ppn_of(s, w));
                chk("R3 R5 attributes of hit", r_attr, attr_of(s, w));
            end
        end

        // R10: idle cycle is quiet
        @(negedge clk);
        chk("R10 idle hit low", lk_hit, 0);
        chk("R10 idle miss low", lk_miss, 0);
        chk("R10 idle ppn zero", lk_ppn, 0);
        chk("R10 idle attr zero", lk_attr, 0);

        // R5 / R6: identifier mismatch misses and captures the page
        lookup(vpn_of(7, 1), 8'h5B);
        chk("R5 identifier mismatch misses", r_miss, 1);
        chk("R5 identifier mismatch no hit", r_hit, 0);
        chk("R10 ppn zero on miss", r_ppn, 0);
        chk("R6 captured page on miss", entry_hi, {vpn_of(7, 1), 2'b00, 8'h5A});

        // R5: page bits 11..10 belong to the tag
        lookup(vpn_of(5, 2) ^ 22'h3, 8'h5A);
        chk("R5 low tag bits compared", r_miss, 1);

        // R6: capture beats a same-edge software write; written identifier kept
        reg_we    = 1'b1;
        reg_sel   = 2'd0;
        reg_wdata = eh_word(22'h3FFFFF, 8'h77);
        lk_req    = 1'b1;
        lk_vaddr  = {15'h1234, 5'd2, 2'd3, 10'h000};
        lk_asid   = 8'h5A;
        @(negedge clk);
        reg_we = 1'b0;
        lk_req = 1'b0;
        chk("R6 miss flagged", lk_miss, 1);
        chk("R6 capture wins collision", entry_hi, {15'h1234, 5'd2, 2'd3, 2'b00, 8'h77});

        // R7: invalid load never hits; R11 other ways untouched
        install(vpn_of(3, 2), 8'h5A, ppn_of(3, 2), attr_of(3, 2), 1'b0, 1'b0, 2);
        lookup(vpn_of(3, 2), 8'h5A);
        chk("R7 invalid entry misses", r_hit, 0);
        for (int w = 0; w < 4; w++) begin
            if (w != 2) begin
                lookup(vpn_of(3, w), 8'h5A);
                chk("R11 neighbour way still hits", r_hit, 1);
                chk("R11 neighbour way ppn", r_ppn, ppn_of(3, w));
            end
        end

        // R9: overwrite an occupied slot
        install({15'h6001, 5'd4, 2'd0}, 8'h5A, 22'h3F0F0, 6'h2A, 1'b1, 1'b0, 1);
        lookup({15'h6001, 5'd4, 2'd0}, 8'h5A);
        chk("R9 new entry hits", r_hit, 1);
        chk("R9 new ppn", r_ppn, 22'h3F0F0);
        chk("R9 new attributes", r_attr, 6'h2A);
        lookup(vpn_of(4, 1), 8'h5A);
        chk("R9 old tag gone", r_hit, 0);

        // R8: load and lookup on the same edge
        wr(2'd0, eh_word({15'h7ABC, 5'd9, 2'd1}, 8'h5A));
        wr(2'd1, el_word(22'h11111, 6'h15, 1'b1));
        wr(2'd2, ctl_word(1'b0, 2));
        ld_en    = 1'b1;
        lk_req   = 1'b1;
        lk_vaddr = {15'h7ABC, 5'd9, 2'd1, 10'h000};
        lk_asid  = 8'h5A;
        @(negedge clk);
        ld_en  = 1'b0;
        lk_req = 1'b0;
        chk("R8 same-edge lookup sees old", lk_miss, 1);
        lookup({15'h7ABC, 5'd9, 2'd1}, 8'h5A);
        chk("R8 following lookup hits", r_hit, 1);
        chk("R8 following ppn", r_ppn, 22'h11111);

        // R1: reset in mid-run clears everything
        do_reset();
        chk("R1 entry_hi cleared", entry_hi, 0);
        for (int s = 0; s < 32; s++) begin
            for (int w = 0; w < 4; w++) begin
                lookup(vpn_of(s, w), 8'h5A);
                chk("R1 entry gone after reset", r_hit, 0);
            end
        end

        // R4: hashed index sweep over all low identifier values
        for (int a = 0; a < 32; a++) begin
            install({15'h0ACE, 5'd21, 2'd2}, 8'(a), 22'(a * 977 + 3), 6'(a), 1'b1, 1'b1, 3);
        end
        for (int a = 0; a < 32; a++) begin
            lookup({15'h0ACE, 5'd21, 2'd2}, 8'(a));
            chk("R4 hashed lookup hits", r_hit, 1);
            chk("R4 hashed lookup ppn", r_ppn, 22'(a * 977 + 3));
        end
        wr(2'd2, ctl_word(1'b0, 0));
        for (int a = 0; a < 32; a++) begin
            lookup({15'h0ACE, 5'd21, 2'd2}, 8'(a));
            chk("R4 plain index hits only where hash is identity", r_hit, (a == 0) ? 1 : 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule